// File: doc/BRIEF.md
# Register Predication Lookup Table

This block is a small associative table used at instruction decode to decide whether a register operand is predicated and, if so, which integer register holds its predicate mask. Software loads entries through a write port. Each entry pairs a key with a value. The key is a register-file select bit (integer or floating-point) plus a 5-bit register number. The value is the 5-bit number of the register that carries the predicate bits.

During decode, three operand lookups are presented in parallel. Each lookup is compared against every valid entry in the same cycle, with no indexed read. Each lookup port returns a hit flag and the predicate register number. A miss means the operand is unpredicated.

Clearing an entry also invalidates every entry with a higher index, so software can shrink the table from the top. Reading the predicate register and applying the mask happen outside this block.

Top module: `predtab_top`

## Requirements
- R1: After reset every entry is invalid, so all lookup ports report no hit.
- R2: A write with `wrEn`=1 and `wrClear`=0 stores the key (`wrKeyFp`, `wrKeyReg`) and the value (`wrPredReg`) into entry `wrIdx` and marks that entry valid on the clock edge. Lookups in the same cycle as the write still see the old contents. Lookups from the next cycle see the new entry.
- R3: A lookup hits only when both the file-select bit and the register number equal those of a valid entry. A select bit of 1 means floating-point and 0 means integer.
- R4: On a miss, `lkHit` is 0 and the port's predicate-number field is 0.
- R5: When several valid entries match the same key, the entry with the lowest index supplies the result.
- R6: A clear (`wrEn`=1 and `wrClear`=1) invalidates entry `wrIdx` and all entries above it. Entries below it keep their contents.
- R7: The three ports are independent. Port p uses `lkFp[p]`, `lkReg[5p+4:5p]`, `lkHit[p]` and `lkPred[5p+4:5p]`, and all three resolve in the same cycle.
- R8: Writing an entry that is already valid replaces its key and value, so the old key no longer matches through that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table update strobe |
| wrClear | input | 1 | With wrEn: clear from wrIdx upward instead of loading |
| wrIdx | input | 3 | Entry index for the update |
| wrKeyFp | input | 1 | Key file select (1 = floating-point) |
| wrKeyReg | input | 5 | Key register number |
| wrPredReg | input | 5 | Register number holding the predicate mask |
| lkFp | input | 3 | File select of each lookup port |
| lkReg | input | 15 | Register numbers of the three lookups, 5 bits each |
| lkHit | output | 3 | Per-port hit flag |
| lkPred | output | 15 | Per-port predicate register number, 5 bits each |

## Verification
The bench programs two entries with the same key and checks that the lower index wins. A reversed priority chain would return the higher entry's value instead. It checks that a key with the same number but the other file misses, which catches a comparator that ignores the select bit.

Clearing a middle entry must remove only that entry and those above it. A design that cleared only one slot would leave stale hits, and one that cleared downward would lose low entries. The bench also looks up a key in the same cycle it is written, which exposes a bypass that would make a write visible a cycle early.

// File: rtl/predtab_pkg.sv
package predtab_pkg;
  parameter int unsigned TabEntries  = 8;
  parameter int unsigned RegNumW     = 5;
  parameter int unsigned LookupPorts = 3;
  localparam int unsigned IdxW = $clog2(TabEntries);
  localparam int unsigned KeyW = RegNumW + 1;

  // strobes from control to storage
  typedef struct packed {
    logic [TabEntries-1:0] load;
    logic [TabEntries-1:0] drop;
  } tabStrobe_t;

  typedef struct packed {
    logic               isFp;
    logic [RegNumW-1:0] regNum;
  } opKey_t;
endpackage

// File: rtl/predtab_ctrl.sv
module predtab_ctrl
  import predtab_pkg::*;
(
  input  logic            wrEn,
  input  logic            wrClear,
  input  logic [IdxW-1:0] wrIdx,
  output tabStrobe_t      strobe
);
  always_comb begin
    strobe = '0;
    for (int e = 0; e < TabEntries; e++) begin
      strobe.load[e] = wrEn && !wrClear && (wrIdx == IdxW'(e));
      strobe.drop[e] = wrEn &&  wrClear && (IdxW'(e) >= wrIdx);
    end
  end
endmodule

// File: rtl/predtab_store.sv
module predtab_store
  import predtab_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  tabStrobe_t                     strobe,
  input  opKey_t                         wrKey,
  input  logic [RegNumW-1:0]             wrPred,
  input  logic [LookupPorts-1:0]         lkFp,
  input  logic [LookupPorts*RegNumW-1:0] lkReg,
  output logic [LookupPorts-1:0]         lkHit,
  output logic [LookupPorts*RegNumW-1:0] lkPred
);
  logic   [TabEntries-1:0] entValid;
  opKey_t                  entKey  [TabEntries];
  logic   [RegNumW-1:0]    entPred [TabEntries];

  for (genvar e = 0; e < TabEntries; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[e] <= 1'b0;
        entKey[e]   <= '0;
        entPred[e]  <= '0;
      end else if (strobe.drop[e]) begin
        entValid[e] <= 1'b0;
      end else if (strobe.load[e]) begin
        entValid[e] <= 1'b1;
        entKey[e]   <= wrKey;
        entPred[e]  <= wrPred;
      end
    end
  end

  // fully parallel compare; scanning downward leaves the lowest match
  for (genvar p = 0; p < LookupPorts; p++) begin : g_port
    opKey_t probe;
    assign probe = '{isFp: lkFp[p], regNum: lkReg[p*RegNumW +: RegNumW]};
    always_comb begin
      lkHit[p] = 1'b0;
      lkPred[p*RegNumW +: RegNumW] = '0;
      for (int e = TabEntries - 1; e >= 0; e--) begin
        if (entValid[e] && entKey[e] == probe) begin
          lkHit[p] = 1'b1;
          lkPred[p*RegNumW +: RegNumW] = entPred[e];
        end
      end
    end
  end
endmodule

// File: rtl/predtab_top.sv
module predtab_top
  import predtab_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           wrClear,
  input  logic [IdxW-1:0]                wrIdx,
  input  logic                           wrKeyFp,
  input  logic [RegNumW-1:0]             wrKeyReg,
  input  logic [RegNumW-1:0]             wrPredReg,
  input  logic [LookupPorts-1:0]         lkFp,
  input  logic [LookupPorts*RegNumW-1:0] lkReg,
  output logic [LookupPorts-1:0]         lkHit,
  output logic [LookupPorts*RegNumW-1:0] lkPred
);
  tabStrobe_t strobe;
  opKey_t     wrKey;

  assign wrKey = '{isFp: wrKeyFp, regNum: wrKeyReg};

  predtab_ctrl u_ctrl (
    .wrEn(wrEn), .wrClear(wrClear), .wrIdx(wrIdx), .strobe(strobe)
  );

  predtab_store u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrKey(wrKey), .wrPred(wrPredReg),
    .lkFp(lkFp), .lkReg(lkReg), .lkHit(lkHit), .lkPred(lkPred)
  );
endmodule

// File: rtl/predtab_checker.sv
module predtab_checker
  import predtab_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           wrEn,
  input logic                           wrClear,
  input logic [IdxW-1:0]                wrIdx,
  input logic                           wrKeyFp,
  input logic [RegNumW-1:0]             wrKeyReg,
  input logic [RegNumW-1:0]             wrPredReg,
  input logic [LookupPorts-1:0]         lkFp,
  input logic [LookupPorts*RegNumW-1:0] lkReg,
  input logic [LookupPorts-1:0]         lkHit,
  input logic [LookupPorts*RegNumW-1:0] lkPred
);
  logic anyLoaded;
  always_ff @(posedge clk) begin
    if (!rstN) anyLoaded <= 1'b0;
    else if (wrEn && !wrClear) anyLoaded <= 1'b1;
  end

  // R1: nothing loaded since reset means no hits
  a_r1_empty_misses: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoaded |-> lkHit == '0);

  // R6: clearing from entry 0 empties the table
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrClear && wrIdx == '0) |=> lkHit == '0);

  for (genvar p = 0; p < LookupPorts; p++) begin : g_chk
    // R4: a miss reports a zero predicate number
    a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
      !lkHit[p] |-> lkPred[p*RegNumW +: RegNumW] == '0);

    // R2/R5: entry 0 written last cycle dominates any lookup of its key
    a_r2_entry0_visible: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && !wrClear && wrIdx == '0) |=>
        (!(lkFp[p] == $past(wrKeyFp) &&
           lkReg[p*RegNumW +: RegNumW] == $past(wrKeyReg)) ||
         (lkHit[p] && lkPred[p*RegNumW +: RegNumW] == $past(wrPredReg))));
  end
endmodule

bind predtab_top predtab_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClear(wrClear), .wrIdx(wrIdx),
  .wrKeyFp(wrKeyFp), .wrKeyReg(wrKeyReg), .wrPredReg(wrPredReg),
  .lkFp(lkFp), .lkReg(lkReg), .lkHit(lkHit), .lkPred(lkPred)
);

// File: tb/tb_predtab_top.sv
module tb_predtab_top;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, wrClear, wrKeyFp;
  logic [2:0]  wrIdx;
  logic [4:0]  wrKeyReg, wrPredReg;
  logic [2:0]  lkFp;
  logic [14:0] lkReg;
  logic [2:0]  lkHit;
  logic [14:0] lkPred;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  predtab_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrClear(wrClear), .wrIdx(wrIdx),
    .wrKeyFp(wrKeyFp), .wrKeyReg(wrKeyReg), .wrPredReg(wrPredReg),
    .lkFp(lkFp), .lkReg(lkReg), .lkHit(lkHit), .lkPred(lkPred)
  );

  task automatic expectPort(input int p, input logic hit, input logic [4:0] pred,
                            input string req);
    logic [4:0] got;
    got = lkPred[p*5 +: 5];
    nChecks++;
    if (lkHit[p] !== hit || got !== pred) begin
      nFails++;
      $display("FAIL %s port%0d: hit=%b pred=%0d expected hit=%b pred=%0d",
               req, p, lkHit[p], got, hit, pred);
    end
  endtask

  task automatic setLookup(input int p, input logic fp, input logic [4:0] r);
    lkFp[p] = fp;
    lkReg[p*5 +: 5] = r;
  endtask

  // update applied at a negedge, captured at the following posedge
  task automatic tableOp(input logic clr, input logic [2:0] idx, input logic fp,
                         input logic [4:0] key, input logic [4:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrClear = clr; wrIdx = idx;
    wrKeyFp = fp; wrKeyReg = key; wrPredReg = val;
    @(negedge clk);
    wrEn = 1'b0; wrClear = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    setLookup(0, 1'b0, 5'd0); setLookup(1, 1'b1, 5'd0); setLookup(2, 1'b0, 5'd31);
    #1;
    for (int p = 0; p < 3; p++) expectPort(p, 1'b0, 5'd0, "R1");
  endtask

  task automatic t_basic();
    // same-cycle lookup sees old state (R2)
    @(negedge clk);
    wrEn = 1'b1; wrClear = 1'b0; wrIdx = 3'd2;
    wrKeyFp = 1'b0; wrKeyReg = 5'd5; wrPredReg = 5'd9;
    setLookup(0, 1'b0, 5'd5);
    #1 expectPort(0, 1'b0, 5'd0, "R2");
    @(negedge clk);
    wrEn = 1'b0;
    setLookup(0, 1'b0, 5'd5); setLookup(1, 1'b1, 5'd5); setLookup(2, 1'b0, 5'd6);
    #1;
    expectPort(0, 1'b1, 5'd9, "R2");
    expectPort(1, 1'b0, 5'd0, "R3");
    expectPort(2, 1'b0, 5'd0, "R4");
  endtask

  task automatic t_multiport();
    tableOp(1'b0, 3'd0, 1'b1, 5'd3, 5'd1);
    tableOp(1'b0, 3'd1, 1'b0, 5'd7, 5'd2);
    setLookup(0, 1'b1, 5'd3); setLookup(1, 1'b0, 5'd7); setLookup(2, 1'b0, 5'd3);
    #1;
    expectPort(0, 1'b1, 5'd1, "R7");
    expectPort(1, 1'b1, 5'd2, "R7");
    expectPort(2, 1'b0, 5'd0, "R3");
  endtask

  task automatic t_priority();
    tableOp(1'b0, 3'd6, 1'b0, 5'd10, 5'd21);
    tableOp(1'b0, 3'd4, 1'b0, 5'd10, 5'd20);
    setLookup(0, 1'b0, 5'd10); setLookup(1, 1'b0, 5'd10); setLookup(2, 1'b1, 5'd10);
    #1;
    expectPort(0, 1'b1, 5'd20, "R5");
    expectPort(1, 1'b1, 5'd20, "R5");
    expectPort(2, 1'b0, 5'd0, "R3");
    tableOp(1'b0, 3'd4, 1'b0, 5'd11, 5'd20);
    setLookup(0, 1'b0, 5'd10); setLookup(1, 1'b0, 5'd11);
    #1;
    expectPort(0, 1'b1, 5'd21, "R8");
    expectPort(1, 1'b1, 5'd20, "R8");
  endtask

  task automatic t_clear();
    tableOp(1'b1, 3'd3, 1'b0, 5'd0, 5'd0);
    setLookup(0, 1'b0, 5'd10); setLookup(1, 1'b0, 5'd11); setLookup(2, 1'b0, 5'd5);
    #1;
    expectPort(0, 1'b0, 5'd0, "R6");
    expectPort(1, 1'b0, 5'd0, "R6");
    expectPort(2, 1'b1, 5'd9, "R6");
    setLookup(0, 1'b1, 5'd3); setLookup(1, 1'b0, 5'd7);
    #1;
    expectPort(0, 1'b1, 5'd1, "R6");
    expectPort(1, 1'b1, 5'd2, "R6");
    tableOp(1'b1, 3'd0, 1'b0, 5'd0, 5'd0);
    setLookup(0, 1'b1, 5'd3); setLookup(1, 1'b0, 5'd7); setLookup(2, 1'b0, 5'd5);
    #1;
    for (int p = 0; p < 3; p++) expectPort(p, 1'b0, 5'd0, "R6");
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrClear = 1'b0; wrIdx = '0;
    wrKeyFp = 1'b0; wrKeyReg = '0; wrPredReg = '0; lkFp = '0; lkReg = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_multiport();
    t_priority();
    t_clear();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule